// File: doc/BRIEF.md
# SDRAM Command Decoder with Per-Bank State Tracking

This block sits beside a synchronous DRAM command bus and watches it. On every rising clock edge it turns the select, row-strobe, column-strobe and write-enable lines, the bank-select bits and the address bit that picks the auto-precharge variant into one command code. It follows the life of each bank through idle, open, reading, reading with auto-precharge, writing and writing with auto-precharge. It judges every command against the current state of the banks. The result is a registered command code, the bank the command named, a flag for a command the state does not allow, the latched full-page setting and the state of every bank.

An illegal command is reported and has no other effect. A legal command moves the banks it concerns. A per-bank end-of-burst input tells the block when a data burst has run out. A plain burst then leaves its bank open, and an auto-precharge burst leaves its bank idle. A full-page flag, captured only by a legal mode-register command, decides whether auto-precharge variants and burst stop are allowed.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `sel_n` high the cycle is a deselect. `cmd_code_o` becomes 0, `illegal_o` stays low, and neither the bank states nor `full_page_o` change because of the command.
- R2: With `sel_n` low, the lines {`row_strobe_n`,`col_strobe_n`,`wr_en_n`} decode as follows: 111 gives no-op (code 1), 110 gives burst stop (2), 101 gives read, 100 gives write, 011 gives activate (7), 010 gives precharge, 001 gives refresh (10) and 000 gives mode-register set (11).
- R3: `ap_flag` picks the variant. For read it gives 3 (low) or 4, read with auto-precharge (high). For write it gives 5 or 6, write with auto-precharge. For precharge it gives 8, one bank, or 9, all banks.
- R4: `bank_sel` picks the bank as a binary number. `cmd_bank_o` repeats it with every command. The state of bank i sits in `bank_state_o[3i+2:3i]`, coded as idle 0, open 1, reading 2, reading with auto-precharge 3, writing 4, writing with auto-precharge 5. After reset all banks are idle, the code is 0, and both `illegal_o` and `full_page_o` are low.
- R5: Activate is legal only on an idle bank, which then becomes open. Activating a bank that is not idle is illegal, even while another bank runs an auto-precharge burst.
- R6: Read and write are legal only on a bank that is open, reading or writing, and only while no auto-precharge burst runs. The target bank moves to the matching read or write state. Any other bank that is reading or writing falls back to open.
- R7: A legal mode-register set captures `mode_full_page` into `full_page_o`. While `full_page_o` is high, read and write with auto-precharge are illegal.
- R8: While any bank is reading or writing with auto-precharge, only deselect, no-op and activation of an idle bank are legal.
- R9: When no auto-precharge burst runs, precharge makes the chosen bank idle and precharge-all makes every bank idle.
- R10: Refresh and mode-register set are legal only when all banks are idle, and they change no bank state.
- R11: Burst stop is legal only while `full_page_o` is high and no auto-precharge burst runs. It moves every reading or writing bank to open.
- R12: A high `burst_done[i]` moves bank i from reading or writing to open, and from either auto-precharge state to idle, unless a legal command in the same cycle moves that bank.
- R13: An illegal command raises `illegal_o` and changes neither `full_page_o` nor any bank state.
- R14: All outputs are registered. A command sampled at one rising edge is reported right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Command select, active low |
| row_strobe_n | input | 1 | Row strobe line, active low |
| col_strobe_n | input | 1 | Column strobe line, active low |
| wr_en_n | input | 1 | Write enable line, active low |
| bank_sel | input | BANK_W | Bank number |
| ap_flag | input | 1 | Auto-precharge / all-banks variant select |
| mode_full_page | input | 1 | Full-page setting, captured by mode-register set |
| burst_done | input | 2**BANK_W | Per-bank end of data burst |
| cmd_code_o | output | 4 | Decoded command code |
| cmd_bank_o | output | BANK_W | Bank named with the command |
| illegal_o | output | 1 | Command not allowed in the current state |
| full_page_o | output | 1 | Latched full-page setting |
| bank_state_o | output | 3*2**BANK_W | Packed per-bank state |

## Verification
The bench builds the block with `BANK_W = 2`, which gives four banks. That is small enough for a bench-side reference model to follow every bank exactly. Directed sequences walk each rule of the legality table first. After them comes a long pseudo-random run. It covers every line pattern, both values of the variant bit and every bank, and it drives end-of-burst pulses and full-page settings. This brings up mixes of open, bursting and auto-precharging banks that directed tests would hardly reach. The run compares all outputs after every single command.

// File: rtl/sdram_dec_pkg.sv
// Package: shared command codes, bank state codes and small helpers.
// Assumes: state codes are fixed by the port contract (3 bits per bank).
package sdram_dec_pkg;

    localparam int ST_W  = 3;
    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_DESL = 4'd0,
        CMD_NOP  = 4'd1,
        CMD_BST  = 4'd2,
        CMD_RD   = 4'd3,
        CMD_RDA  = 4'd4,
        CMD_WR   = 4'd5,
        CMD_WRA  = 4'd6,
        CMD_ACT  = 4'd7,
        CMD_PRE  = 4'd8,
        CMD_PALL = 4'd9,
        CMD_REF  = 4'd10,
        CMD_MRS  = 4'd11
    } cmd_e;

    typedef enum logic [ST_W-1:0] {
        BK_IDLE = 3'd0,
        BK_OPEN = 3'd1,
        BK_RD   = 3'd2,
        BK_RDA  = 3'd3,
        BK_WR   = 3'd4,
        BK_WRA  = 3'd5
    } bank_st_e;

    // Bank is in a plain (terminable) burst.
    function automatic logic st_plain_burst(input bank_st_e s);
        return (s == BK_RD) || (s == BK_WR);
    endfunction

    // Bank is in a burst that must run to completion.
    function automatic logic st_ap_burst(input bank_st_e s);
        return (s == BK_RDA) || (s == BK_WRA);
    endfunction

    // Bank has an open row that accepts a column command.
    function automatic logic st_col_ok(input bank_st_e s);
        return (s == BK_OPEN) || (s == BK_RD) || (s == BK_WR);
    endfunction

    // Column command code to the bank state it starts.
    function automatic bank_st_e col_target(input cmd_e c);
        bank_st_e r;
        case (c)
            CMD_RD:  r = BK_RD;
            CMD_RDA: r = BK_RDA;
            CMD_WR:  r = BK_WR;
            CMD_WRA: r = BK_WRA;
            default: r = BK_OPEN;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdram_pin_decoder.sv
// Module: turns the raw command lines into a command code.
// Assumes: all lines are sampled in the same cycle; no state is kept here.
module sdram_pin_decoder
    import sdram_dec_pkg::*;
(
    input  logic sel_n,
    input  logic row_strobe_n,
    input  logic col_strobe_n,
    input  logic wr_en_n,
    input  logic ap_flag,
    output cmd_e cmd
);

    // Map line pattern plus variant bit to one command code.
    always_comb begin
        if (sel_n) begin
            cmd = CMD_DESL;
        end else begin
            case ({row_strobe_n, col_strobe_n, wr_en_n})
                3'b111:  cmd = CMD_NOP;
                3'b110:  cmd = CMD_BST;
                3'b101:  cmd = ap_flag ? CMD_RDA  : CMD_RD;
                3'b100:  cmd = ap_flag ? CMD_WRA  : CMD_WR;
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = ap_flag ? CMD_PALL : CMD_PRE;
                3'b001:  cmd = CMD_REF;
                default: cmd = CMD_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdram_cmd_legality.sv
// Module: judges one command against the current state of every bank.
// Assumes: NUM_BANKS equals 2**BANK_W so every bank number is valid.
module sdram_cmd_legality
    import sdram_dec_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int NUM_BANKS = 1 << BANK_W
) (
    input  cmd_e                        cmd,
    input  logic [BANK_W-1:0]           bank_sel,
    input  logic [NUM_BANKS*ST_W-1:0]   st_flat,
    input  logic                        full_page,
    output logic                        legal
);

    logic     any_ap;
    logic     all_idle;
    bank_st_e tgt;

    // Summaries over all banks and the state of the named bank.
    always_comb begin
        any_ap   = 1'b0;
        all_idle = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (st_ap_burst(bank_st_e'(st_flat[i*ST_W +: ST_W]))) any_ap = 1'b1;
            if (bank_st_e'(st_flat[i*ST_W +: ST_W]) != BK_IDLE) all_idle = 1'b0;
        end
        tgt = bank_st_e'(st_flat[bank_sel*ST_W +: ST_W]);
    end

    // Rule table per command.
    always_comb begin
        case (cmd)
            CMD_DESL, CMD_NOP:        legal = 1'b1;
            CMD_BST:                  legal = full_page && !any_ap;
            CMD_RD, CMD_WR:           legal = !any_ap && st_col_ok(tgt);
            CMD_RDA, CMD_WRA:         legal = !any_ap && st_col_ok(tgt) && !full_page;
            CMD_ACT:                  legal = (tgt == BK_IDLE);
            CMD_PRE, CMD_PALL:        legal = !any_ap;
            CMD_REF, CMD_MRS:         legal = all_idle;
            default:                  legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
// Module: state register of one bank.
// Assumes: legality has been judged upstream; a legal command that moves
// this bank takes priority over its end-of-burst pulse.
module sdram_bank_fsm
    import sdram_dec_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int IDX    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic              cmd_legal,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              burst_done,
    output bank_st_e          state
);

    logic     hit;
    logic     touched;
    bank_st_e cmd_next;
    bank_st_e nxt;

    assign hit = (bank_sel == BANK_W'(IDX));

    // Effect of a legal command on this bank.
    always_comb begin
        touched  = 1'b0;
        cmd_next = state;
        if (cmd_legal) begin
            case (cmd)
                CMD_BST: begin
                    if (st_plain_burst(state)) begin
                        cmd_next = BK_OPEN;
                        touched  = 1'b1;
                    end
                end
                CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
                    if (hit) begin
                        cmd_next = col_target(cmd);
                        touched  = 1'b1;
                    end else if (st_plain_burst(state)) begin
                        cmd_next = BK_OPEN;
                        touched  = 1'b1;
                    end
                end
                CMD_ACT: begin
                    if (hit) begin
                        cmd_next = BK_OPEN;
                        touched  = 1'b1;
                    end
                end
                CMD_PRE: begin
                    if (hit) begin
                        cmd_next = BK_IDLE;
                        touched  = 1'b1;
                    end
                end
                CMD_PALL: begin
                    cmd_next = BK_IDLE;
                    touched  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Merge command effect with the end-of-burst pulse.
    always_comb begin
        nxt = cmd_next;
        if (!touched && burst_done) begin
            if (st_plain_burst(state))   nxt = BK_OPEN;
            else if (st_ap_burst(state)) nxt = BK_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= BK_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
// Module: top of the command decoder with bank tracking.
// Assumes: the command lines are synchronous to clk; one command per cycle.
module sdram_cmd_tracker
    import sdram_dec_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sel_n,
    input  logic                             row_strobe_n,
    input  logic                             col_strobe_n,
    input  logic                             wr_en_n,
    input  logic [BANK_W-1:0]                bank_sel,
    input  logic                             ap_flag,
    input  logic                             mode_full_page,
    input  logic [(1<<BANK_W)-1:0]           burst_done,
    output logic [CMD_W-1:0]                 cmd_code_o,
    output logic [BANK_W-1:0]                cmd_bank_o,
    output logic                             illegal_o,
    output logic                             full_page_o,
    output logic [(1<<BANK_W)*ST_W-1:0]      bank_state_o
);

    localparam int NUM_BANKS = 1 << BANK_W;

    cmd_e                       cmd;
    logic                       legal;
    logic [NUM_BANKS*ST_W-1:0]  st_flat;
    bank_st_e                   st_arr [NUM_BANKS];
    logic                       fp_q;

    sdram_pin_decoder u_dec (
        .sel_n        (sel_n),
        .row_strobe_n (row_strobe_n),
        .col_strobe_n (col_strobe_n),
        .wr_en_n      (wr_en_n),
        .ap_flag      (ap_flag),
        .cmd          (cmd)
    );

    sdram_cmd_legality #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) u_legal (
        .cmd       (cmd),
        .bank_sel  (bank_sel),
        .st_flat   (st_flat),
        .full_page (fp_q),
        .legal     (legal)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_fsm #(.BANK_W(BANK_W), .IDX(b)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd        (cmd),
            .cmd_legal  (legal),
            .bank_sel   (bank_sel),
            .burst_done (burst_done[b]),
            .state      (st_arr[b])
        );
        assign st_flat[b*ST_W +: ST_W] = st_arr[b];
    end

    // Full-page setting, captured only by a legal mode-register set.
    always_ff @(posedge clk) begin
        if (!rst_n)                          fp_q <= 1'b0;
        else if (legal && cmd == CMD_MRS)    fp_q <= mode_full_page;
    end

    // Registered report of the command just sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code_o <= CMD_DESL;
            cmd_bank_o <= '0;
            illegal_o  <= 1'b0;
        end else begin
            cmd_code_o <= cmd;
            cmd_bank_o <= bank_sel;
            illegal_o  <= !legal;
        end
    end

    assign full_page_o  = fp_q;
    assign bank_state_o = st_flat;

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
// Module: property checker for the tracker, bound to every instance.
// Assumes: observes only the ports of the top module.
module sdram_cmd_tracker_chk
    import sdram_dec_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [(1<<BANK_W)-1:0]       burst_done,
    input logic [CMD_W-1:0]             cmd_code_o,
    input logic [BANK_W-1:0]            cmd_bank_o,
    input logic                         illegal_o,
    input logic                         full_page_o,
    input logic [(1<<BANK_W)*ST_W-1:0]  bank_state_o
);

    localparam int NUM_BANKS = 1 << BANK_W;

    logic                 past_ok;
    logic [NUM_BANKS-1:0] busy_vec;
    logic [NUM_BANKS-1:0] ap_vec;

    // Marks cycles whose history lies entirely after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Which banks hold a data burst, and which an auto-precharge burst.
    always_comb begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            busy_vec[i] = bank_state_o[i*ST_W +: ST_W] >= 3'd2 &&
                          bank_state_o[i*ST_W +: ST_W] <= 3'd5;
            ap_vec[i]   = bank_state_o[i*ST_W +: ST_W] == 3'd3 ||
                          bank_state_o[i*ST_W +: ST_W] == 3'd5;
        end
    end

    assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_code_o == 4'd0 |-> !illegal_o);

    assert_act_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code_o == 4'd7 && !illegal_o) |-> bank_state_o[cmd_bank_o*ST_W +: ST_W] == 3'd1);

    assert_one_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy_vec) <= 1);

    assert_ap_fullpage_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code_o == 4'd4 || cmd_code_o == 4'd6) && !illegal_o) |-> !full_page_o);

    assert_ap_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ap_vec) != '0 && !illegal_o) |->
        (cmd_code_o == 4'd0 || cmd_code_o == 4'd1 || cmd_code_o == 4'd7));

    assert_pall_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code_o == 4'd9 && !illegal_o) |-> bank_state_o == '0);

    assert_refmrs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (cmd_code_o == 4'd10 || cmd_code_o == 4'd11) && !illegal_o) |->
        ($past(bank_state_o) == '0 && bank_state_o == '0));

    assert_illegal_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && illegal_o && $past(burst_done) == '0) |->
        ($stable(bank_state_o) && $stable(full_page_o)));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.BANK_W(BANK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_done   (burst_done),
    .cmd_code_o   (cmd_code_o),
    .cmd_bank_o   (cmd_bank_o),
    .illegal_o    (illegal_o),
    .full_page_o  (full_page_o),
    .bank_state_o (bank_state_o)
);

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;

    localparam int BANK_W = 2;
    localparam int NB     = 1 << BANK_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sel_n = 1'b1, row_strobe_n = 1'b1, col_strobe_n = 1'b1, wr_en_n = 1'b1;
    logic [1:0]      bank_sel = '0;
    logic            ap_flag = 1'b0, mode_full_page = 1'b0;
    logic [NB-1:0]   burst_done = '0;
    logic [3:0]      cmd_code_o;
    logic [1:0]      cmd_bank_o;
    logic            illegal_o, full_page_o;
    logic [NB*3-1:0] bank_state_o;

    always #2 clk = ~clk;

    sdram_cmd_tracker #(.BANK_W(BANK_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_strobe_n(row_strobe_n),
        .col_strobe_n(col_strobe_n), .wr_en_n(wr_en_n), .bank_sel(bank_sel),
        .ap_flag(ap_flag), .mode_full_page(mode_full_page), .burst_done(burst_done),
        .cmd_code_o(cmd_code_o), .cmd_bank_o(cmd_bank_o), .illegal_o(illegal_o),
        .full_page_o(full_page_o), .bank_state_o(bank_state_o)
    );

    int    checks = 0, fails = 0;
    bit    finished = 0;
    int    mst [NB];
    bit    mfp = 0;
    bit    pend = 0;
    string pend_tag;
    logic [3:0]      e_cmd;
    logic [1:0]      e_bank;
    logic            e_ill, e_fp;
    logic [NB*3-1:0] e_st;

    // Compare outputs with the prediction for the last command.
    task automatic check_out();
        if (pend) begin
            checks++;
            if ({cmd_code_o, cmd_bank_o, illegal_o, full_page_o, bank_state_o} !==
                {e_cmd, e_bank, e_ill, e_fp, e_st}) begin
                fails++;
                $display("FAIL %s: got cmd=%0d bank=%0d ill=%0b fp=%0b st=%h, expected cmd=%0d bank=%0d ill=%0b fp=%0b st=%h",
                         pend_tag, cmd_code_o, cmd_bank_o, illegal_o, full_page_o, bank_state_o,
                         e_cmd, e_bank, e_ill, e_fp, e_st);
            end
            pend = 0;
        end
    endtask

    // Reference model of one cycle, from the requirements.
    task automatic model(input logic s, input logic [2:0] p, input logic [1:0] b,
                         input logic a, input logic fin, input logic [NB-1:0] dn,
                         output string tg);
        int  code;
        bit  lg, any_ap, all_idle;
        int  nst [NB];
        bit  tch [NB];
        if (s) code = 0;
        else case (p)
            3'b111: code = 1;
            3'b110: code = 2;
            3'b101: code = a ? 4 : 3;
            3'b100: code = a ? 6 : 5;
            3'b011: code = 7;
            3'b010: code = a ? 9 : 8;
            3'b001: code = 10;
            default: code = 11;
        endcase
        any_ap = 0; all_idle = 1;
        for (int i = 0; i < NB; i++) begin
            if (mst[i] == 3 || mst[i] == 5) any_ap = 1;
            if (mst[i] != 0) all_idle = 0;
            nst[i] = mst[i]; tch[i] = 0;
        end
        case (code)
            0, 1:    lg = 1;
            2:       lg = mfp && !any_ap;
            3, 5:    lg = !any_ap && (mst[b] == 1 || mst[b] == 2 || mst[b] == 4);
            4, 6:    lg = !any_ap && (mst[b] == 1 || mst[b] == 2 || mst[b] == 4) && !mfp;
            7:       lg = (mst[b] == 0);
            8, 9:    lg = !any_ap;
            default: lg = all_idle;
        endcase
        if (lg) begin
            for (int i = 0; i < NB; i++) begin
                case (code)
                    2: if (mst[i] == 2 || mst[i] == 4) begin nst[i] = 1; tch[i] = 1; end
                    3, 4, 5, 6: begin
                        if (i == b) begin nst[i] = code - 1; tch[i] = 1; end
                        else if (mst[i] == 2 || mst[i] == 4) begin nst[i] = 1; tch[i] = 1; end
                    end
                    7: if (i == b) begin nst[i] = 1; tch[i] = 1; end
                    8: if (i == b) begin nst[i] = 0; tch[i] = 1; end
                    9: begin nst[i] = 0; tch[i] = 1; end
                    default: ;
                endcase
            end
            if (code == 11) mfp = fin;
        end
        for (int i = 0; i < NB; i++) begin
            if (!tch[i] && dn[i]) begin
                if (mst[i] == 2 || mst[i] == 4) nst[i] = 1;
                else if (mst[i] == 3 || mst[i] == 5) nst[i] = 0;
            end
            mst[i] = nst[i];
            e_st[i*3 +: 3] = 3'(nst[i]);
        end
        e_cmd = 4'(code); e_bank = b; e_ill = !lg; e_fp = mfp;
        if (!lg) tg = "R13";
        else case (code)
            0: tg = "R1";  1: tg = "R2";  2: tg = "R11";
            3, 5: tg = "R6"; 4, 6: tg = "R7"; 7: tg = "R5";
            8, 9: tg = "R9"; default: tg = "R10";
        endcase
    endtask

    // Apply one command at the falling edge; checked at the next one.
    task automatic step(input logic s, input logic [2:0] p, input logic [1:0] b,
                        input logic a, input logic fin, input logic [NB-1:0] dn,
                        input string tag);
        string tg;
        @(negedge clk);
        check_out();
        sel_n = s; {row_strobe_n, col_strobe_n, wr_en_n} = p;
        bank_sel = b; ap_flag = a; mode_full_page = fin; burst_done = dn;
        model(s, p, b, a, fin, dn, tg);
        pend_tag = (tag == "") ? tg : tag;
        pend = 1;
    endtask

    localparam logic [2:0] P_NOP = 3'b111, P_BST = 3'b110, P_RD = 3'b101, P_WR = 3'b100,
                           P_ACT = 3'b011, P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000;

    initial begin
        #(4 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < NB; i++) mst[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        e_cmd = 0; e_bank = 0; e_ill = 0; e_fp = 0; e_st = '0; pend = 1; pend_tag = "R14";
        check_out();

        step(1, P_RD,  2'd3, 1, 1, '0, "R1");   // deselect ignores pins
        step(0, P_MRS, 2'd0, 0, 1, '0, "R7");   // latch full page
        step(0, P_ACT, 2'd2, 0, 0, '0, "R5");
        step(0, P_ACT, 2'd2, 0, 0, '0, "R5");   // same bank again: illegal
        step(0, P_RD,  2'd2, 1, 0, '0, "R7");   // AP with full page: illegal
        step(0, P_RD,  2'd2, 0, 0, '0, "R3");
        step(0, P_BST, 2'd0, 0, 0, '0, "R11");
        step(0, P_REF, 2'd0, 0, 0, '0, "R10");  // bank open: illegal
        for (int b = 0; b < NB; b++)
            step(0, P_ACT, 2'(b), 0, 0, '0, "R4");
        step(0, P_WR,  2'd1, 0, 0, '0, "R6");
        step(0, P_RD,  2'd0, 0, 0, '0, "R6");   // bank1 write ends
        step(0, P_NOP, 2'd0, 0, 0, 4'b0001, "R12");
        step(0, P_PRE, 2'd0, 1, 0, '0, "R9");
        step(0, P_MRS, 2'd0, 0, 0, '0, "R10");
        step(0, P_ACT, 2'd0, 0, 0, '0, "R5");
        step(0, P_WR,  2'd0, 1, 0, '0, "R3");
        step(0, P_RD,  2'd1, 0, 0, '0, "R8");
        step(0, P_PRE, 2'd0, 0, 0, '0, "R8");
        step(0, P_BST, 2'd0, 0, 0, '0, "R8");
        step(0, P_ACT, 2'd1, 0, 0, '0, "R8");
        step(0, P_ACT, 2'd0, 0, 0, '0, "R8");
        step(0, P_NOP, 2'd0, 0, 0, 4'b0001, "R12");
        step(0, P_PRE, 2'd1, 0, 0, '0, "R9");
        step(0, P_REF, 2'd0, 0, 0, '0, "R10");

        r = 32'h1234_5678;
        for (int n = 0; n < 30000; n++) begin
            r = r * 32'd1103515245 + 32'd12345;
            step(r[19:16] == 4'd0, r[22:20], r[24:23], r[25], r[26],
                 {r[27] & r[28] & r[29], r[28] & r[30] & r[31], r[29] & r[31] & r[10],
                  r[30] & r[11] & r[12]}, "");
        end
        @(negedge clk);
        check_out();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule